// File: doc/BRIEF.md
# Register Window Pointer and Invalid-Mask Controller

This block tracks which register window a windowed integer core is using. It also holds a per-window mask that marks windows that may not be entered. Each cycle it accepts single-cycle request pulses. A call-side save steps the pointer down by one window. A return and a return-from-trap each step it up by one window. Entering a trap handler steps it down by one window. Before a save, return or return-from-trap moves the pointer, the block looks up the destination window in the mask. A marked destination is refused, and the block raises an overflow trap (for a save) or an underflow trap (for a return). Window numbers wrap around modulo the window count.

Handler software reaches the mask through a write port. A trap handler typically spills or fills one window, rotates the single marked bit by one position, and then retries the refused instruction. Moving data to and from memory is not part of this block.

The control is a three-state machine. `ST_RUN` is the quiet state. `ST_OVF` lasts one cycle and drives the overflow flag. `ST_UNF` lasts one cycle and drives the underflow flag. The machine has the following transitions:
- Every state goes to `ST_OVF` on a refused save.
- Every state goes to `ST_UNF` on a refused return.
- In every other case, every state goes back to `ST_RUN`.

Back-to-back refused requests therefore keep the machine in a flag state for as many cycles as there are refusals. Incoming requests are first reduced to one operation, in priority order: `OP_TRAP`, then `OP_SAVE`, then `OP_RETURN`, then `OP_IDLE`.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer reads 0, the mask reads the one-hot value of window 1 (0x00000002 with defaults), and both trap flags are low.
- R2: A save to an unmarked window moves the pointer from p to p-1 at the next clock edge. The move from 0 goes to NWIN-1 (7 with defaults).
- R3: A save whose destination window has its mask bit set leaves the pointer unchanged. It also raises the overflow flag for the one cycle after that edge. A save retried after the handler has moved the mask bit then succeeds.
- R4: A return or return-from-trap to an unmarked window moves the pointer from p to p+1. The move from NWIN-1 goes to 0.
- R5: A return or return-from-trap whose destination has its mask bit set leaves the pointer unchanged. It also raises the underflow flag for exactly the one following cycle.
- R6: Trap entry moves the pointer from p to p-1 (with wrap) even when that window is marked, and it raises no flag.
- R7: When several requests arrive in the same cycle, only one move is made. Trap entry is served first, then save, then return or return-from-trap. A return and a return-from-trap together count as a single step up.
- R8: A mask write takes effect at the next edge. Bits at positions NWIN and above are stored as 0.
- R9: A move requested in the same cycle as a mask write is checked against the mask value held before that edge.
- R10: The pointer is always below NWIN, and the two trap flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Save request pulse (pointer down) |
| restore_req | input | 1 | Return request pulse (pointer up) |
| rett_req | input | 1 | Return-from-trap request pulse (pointer up) |
| trap_req | input | 1 | Trap entry pulse (pointer down, unchecked) |
| wim_we | input | 1 | Mask write enable |
| wim_wdata | input | MW (32) | Mask write value |
| cwp | output | CW (5) | Current window number |
| wim | output | MW (32) | Invalid-window mask |
| ovf_trap | output | 1 | Window overflow flag, one cycle per refused save |
| unf_trap | output | 1 | Window underflow flag, one cycle per refused return |

## Verification
A wrong pointer value appears on `cwp` one cycle after the request that produced it. A wrong modular step shows up the first time a move crosses the 0 and NWIN-1 boundary. A wrong mask lookup is seen in the same cycle as a pointer that moved when it should not have, or did not move when it should have. The same lookup error also shows as a missing or spurious flag. A state machine stuck in a flag state shows as a flag that stays high into the following idle cycle. A wrong write mask shows as high bits on `wim` one cycle after the write. Every scenario samples the ports one cycle after each request, so each fault is caught at the first operation that exposes it.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // operation selected from the request pulses in one cycle
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_TRAP   = 2'd1,
        OP_SAVE   = 2'd2,
        OP_RETURN = 2'd3
    } win_op_e;

    // controller state; the flag states last one cycle each
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OVF = 2'd1,
        ST_UNF = 2'd2
    } win_st_e;

endpackage

// File: rtl/regwin_req_arb.sv
module regwin_req_arb
    import regwin_pkg::*;
(
    input  logic    save_req,
    input  logic    restore_req,
    input  logic    rett_req,
    input  logic    trap_req,
    output win_op_e op
);

    // fixed priority: trap entry, save, then either upward request
    always_comb begin
        if (trap_req) begin
            op = OP_TRAP;
        end else if (save_req) begin
            op = OP_SAVE;
        end else if (restore_req || rett_req) begin
            op = OP_RETURN;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/regwin_step.sv
module regwin_step #(
    parameter int NWIN = 8,
    parameter int CW   = 5
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] dec_idx,
    output logic [CW-1:0] inc_idx
);

    localparam int  IW   = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam bit  POW2 = ((NWIN & (NWIN - 1)) == 0);

    generate
        if (POW2) begin : g_pow2
            // power-of-two count: wrap falls out of the low index bits
            logic [IW-1:0] lo;
            logic [IW-1:0] lo_dn;
            logic [IW-1:0] lo_up;
            assign lo      = cur[IW-1:0];
            assign lo_dn   = lo - IW'(1);
            assign lo_up   = lo + IW'(1);
            assign dec_idx = CW'(lo_dn);
            assign inc_idx = CW'(lo_up);
        end else begin : g_cmp
            // any other count: explicit compare at both ends
            assign dec_idx = (cur == '0) ? CW'(NWIN - 1) : cur - CW'(1);
            assign inc_idx = (cur == CW'(NWIN - 1)) ? '0 : cur + CW'(1);
        end
    endgenerate

endmodule

// File: rtl/regwin_mask.sv
module regwin_mask #(
    parameter int NWIN        = 8,
    parameter int CW          = 5,
    parameter int MW          = 32,
    parameter int RST_INVALID = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [MW-1:0] wdata,
    input  logic [CW-1:0] dec_idx,
    input  logic [CW-1:0] inc_idx,
    output logic          dec_hit,
    output logic          inc_hit,
    output logic [MW-1:0] mask
);

    localparam logic [MW-1:0] RST_VAL = MW'(1) << RST_INVALID;

    logic [MW-1:0] clean;
    logic [MW-1:0] mask_q;

    // positions that name no window are dropped on write
    generate
        for (genvar b = 0; b < MW; b++) begin : g_bit
            if (b < NWIN) begin : g_keep
                assign clean[b] = wdata[b];
            end else begin : g_drop
                assign clean[b] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= RST_VAL;
        end else if (we) begin
            mask_q <= clean;
        end
    end

    // lookups use the value held before this edge
    assign dec_hit = mask_q[dec_idx];
    assign inc_hit = mask_q[inc_idx];
    assign mask    = mask_q;

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN        = 8,
    parameter int CW          = 5,
    parameter int MW          = 32,
    parameter int RST_INVALID = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic          rett_req,
    input  logic          trap_req,
    input  logic          wim_we,
    input  logic [MW-1:0] wim_wdata,
    output logic [CW-1:0] cwp,
    output logic [MW-1:0] wim,
    output logic          ovf_trap,
    output logic          unf_trap
);

    win_op_e       op;
    win_st_e       st_q;
    win_st_e       st_d;
    logic [CW-1:0] cwp_q;
    logic [CW-1:0] cwp_d;
    logic [CW-1:0] dec_idx;
    logic [CW-1:0] inc_idx;
    logic          dec_hit;
    logic          inc_hit;

    regwin_req_arb u_arb (
        .save_req    (save_req),
        .restore_req (restore_req),
        .rett_req    (rett_req),
        .trap_req    (trap_req),
        .op          (op)
    );

    regwin_step #(
        .NWIN (NWIN),
        .CW   (CW)
    ) u_step (
        .cur     (cwp_q),
        .dec_idx (dec_idx),
        .inc_idx (inc_idx)
    );

    regwin_mask #(
        .NWIN        (NWIN),
        .CW          (CW),
        .MW          (MW),
        .RST_INVALID (RST_INVALID)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wim_we),
        .wdata   (wim_wdata),
        .dec_idx (dec_idx),
        .inc_idx (inc_idx),
        .dec_hit (dec_hit),
        .inc_hit (inc_hit),
        .mask    (wim)
    );

    // next pointer and next state from the chosen operation
    always_comb begin
        cwp_d = cwp_q;
        st_d  = ST_RUN;
        unique case (op)
            OP_TRAP: begin
                cwp_d = dec_idx;
            end
            OP_SAVE: begin
                if (dec_hit) begin
                    st_d = ST_OVF;
                end else begin
                    cwp_d = dec_idx;
                end
            end
            OP_RETURN: begin
                if (inc_hit) begin
                    st_d = ST_UNF;
                end else begin
                    cwp_d = inc_idx;
                end
            end
            default: begin
            end
        endcase
    end

    // state and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cwp_q <= '0;
        end else begin
            st_q  <= st_d;
            cwp_q <= cwp_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        ovf_trap = 1'b0;
        unf_trap = 1'b0;
        unique case (st_q)
            ST_OVF:  ovf_trap = 1'b1;
            ST_UNF:  unf_trap = 1'b1;
            default: begin
            end
        endcase
    end

    assign cwp = cwp_q;

endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
    parameter int NWIN = 8,
    parameter int CW   = 5,
    parameter int MW   = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          save_req,
    input logic          restore_req,
    input logic          rett_req,
    input logic          trap_req,
    input logic [CW-1:0] cwp,
    input logic [MW-1:0] wim,
    input logic          ovf_trap,
    input logic          unf_trap
);

    localparam logic [MW-1:0] VALID = (NWIN >= MW) ? '1 : MW'((64'(1) << NWIN) - 64'(1));

    function automatic logic [CW-1:0] down1(input logic [CW-1:0] v);
        return (v == '0) ? CW'(NWIN - 1) : v - CW'(1);
    endfunction

    function automatic logic [CW-1:0] up1(input logic [CW-1:0] v);
        return (v >= CW'(NWIN - 1)) ? '0 : v + CW'(1);
    endfunction

    p_cwp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cwp < CW'(NWIN));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !trap_req && !wim[down1(cwp)])
        |=> (cwp == down1($past(cwp))) && !ovf_trap);

    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> ($past(save_req) && !$past(trap_req) && $stable(cwp)));

    p_restore_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((restore_req || rett_req) && !save_req && !trap_req && !wim[up1(cwp)])
        |=> (cwp == up1($past(cwp))) && !unf_trap);

    p_unf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> (($past(restore_req) || $past(rett_req)) && !$past(save_req)
                      && !$past(trap_req) && $stable(cwp)));

    p_trap_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (cwp == down1($past(cwp))) && !ovf_trap && !unf_trap);

    p_mask_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wim & ~VALID) == '0);

endmodule

bind regwin_ctrl regwin_ctrl_chk #(
    .NWIN (NWIN),
    .CW   (CW),
    .MW   (MW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rett_req    (rett_req),
    .trap_req    (trap_req),
    .cwp         (cwp),
    .wim         (wim),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/regwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;

    localparam int NWIN = 8;
    localparam int CW   = 5;
    localparam int MW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0;
    logic          restore_req = 1'b0;
    logic          rett_req = 1'b0;
    logic          trap_req = 1'b0;
    logic          wim_we = 1'b0;
    logic [MW-1:0] wim_wdata = '0;
    logic [CW-1:0] cwp;
    logic [MW-1:0] wim;
    logic          ovf_trap;
    logic          unf_trap;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    regwin_ctrl #(.NWIN(NWIN), .CW(CW), .MW(MW), .RST_INVALID(1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .rett_req    (rett_req),
        .trap_req    (trap_req),
        .wim_we      (wim_we),
        .wim_wdata   (wim_wdata),
        .cwp         (cwp),
        .wim         (wim),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    // one request cycle, then sample one cycle after the edge
    task automatic step(input logic s, input logic r, input logic rt,
                        input logic tr, input logic we, input logic [MW-1:0] wd);
        @(negedge clk);
        save_req = s; restore_req = r; rett_req = rt; trap_req = tr;
        wim_we = we; wim_wdata = wd;
        @(negedge clk);
        save_req = 0; restore_req = 0; rett_req = 0; trap_req = 0;
        wim_we = 0; wim_wdata = '0;
    endtask

    task automatic expect_all(input string tag, input int c, input logic [MW-1:0] m,
                              input logic o, input logic u);
        n_chk++;
        if (cwp !== CW'(c)) begin
            n_bad++; $display("FAIL %s cwp actual=%0d expected=%0d", tag, cwp, c);
        end
        n_chk++;
        if (wim !== m) begin
            n_bad++; $display("FAIL %s wim actual=%h expected=%h", tag, wim, m);
        end
        n_chk++;
        if (ovf_trap !== o) begin
            n_bad++; $display("FAIL %s ovf actual=%0b expected=%0b", tag, ovf_trap, o);
        end
        n_chk++;
        if (unf_trap !== u) begin
            n_bad++; $display("FAIL %s unf actual=%0b expected=%0b", tag, unf_trap, u);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_all("R1 reset", 0, 32'h2, 0, 0);
    endtask

    task automatic t_underflow_at_start();
        step(0, 1, 0, 0, 0, '0);
        expect_all("R5 restore onto invalid", 0, 32'h2, 0, 1);
        step(0, 0, 0, 0, 0, '0);
        expect_all("R5 flag single cycle", 0, 32'h2, 0, 0);
    endtask

    task automatic t_wraps();
        step(1, 0, 0, 0, 0, '0);
        expect_all("R2 save wrap 0 to 7", 7, 32'h2, 0, 0);
        step(0, 0, 1, 0, 0, '0);
        expect_all("R4 rett wrap 7 to 0", 0, 32'h2, 0, 0);
    endtask

    task automatic t_overflow_handler();
        for (int k = 7; k >= 2; k--) begin
            step(1, 0, 0, 0, 0, '0);
            expect_all("R2 save chain", k, 32'h2, 0, 0);
        end
        step(1, 0, 0, 0, 0, '0);
        expect_all("R3 save onto invalid", 2, 32'h2, 1, 0);
        // handler: rotate the marked bit right by one within NWIN bits
        step(0, 0, 0, 0, 1, 32'h1);
        expect_all("R3 R8 mask rotated", 2, 32'h1, 0, 0);
        step(1, 0, 0, 0, 0, '0);
        expect_all("R3 retried save", 1, 32'h1, 0, 0);
    endtask

    task automatic t_trap_entry();
        step(0, 0, 0, 1, 0, '0);
        expect_all("R6 trap onto invalid", 0, 32'h1, 0, 0);
    endtask

    task automatic t_priority();
        step(1, 0, 0, 1, 0, '0);
        expect_all("R7 trap over save", 7, 32'h1, 0, 0);
        step(1, 1, 0, 0, 0, '0);
        expect_all("R7 save over restore", 6, 32'h1, 0, 0);
        step(0, 1, 1, 0, 0, '0);
        expect_all("R7 restore and rett single step", 7, 32'h1, 0, 0);
    endtask

    task automatic t_mask_write();
        step(0, 0, 0, 0, 1, 32'hFFFF_FF80);
        expect_all("R8 high bits dropped", 7, 32'h80, 0, 0);
        step(1, 0, 0, 0, 0, '0);
        expect_all("R2 save 7 to 6", 6, 32'h80, 0, 0);
        step(0, 1, 0, 0, 0, '0);
        expect_all("R5 restore onto window 7", 6, 32'h80, 0, 1);
    endtask

    task automatic t_same_cycle_write();
        step(1, 0, 0, 0, 1, 32'h20);
        expect_all("R9 old mask allows save", 5, 32'h20, 0, 0);
        step(0, 0, 0, 0, 1, 32'h10);
        expect_all("R8 mask write", 5, 32'h10, 0, 0);
        step(1, 0, 0, 0, 1, 32'h0);
        expect_all("R9 old mask refuses save", 5, 32'h0, 1, 0);
        step(0, 0, 0, 0, 0, '0);
        expect_all("R10 flags clear", 5, 32'h0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_underflow_at_start();
        t_wraps();
        t_overflow_handler();
        t_trap_entry();
        t_priority();
        t_mask_write();
        t_same_cycle_write();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule